// File: doc/BRIEF.md
# Microcoded Accumulator Computer

A small 16-bit accumulator machine whose control comes entirely from a 128-word by 20-bit microprogram. The machine has an 11-bit program counter and an 11-bit address register, 16-bit data and accumulator registers, and a 2048 by 16 word-addressed main memory. Registers are connected by multiplexers rather than a shared bus. Each microinstruction carries three 3-bit operation fields, a 2-bit condition select, a 2-bit branch type and a 7-bit target. Each operation field can start one register transfer per clock, so up to three transfers happen in one cycle.

Instruction words use this layout: bit 15 is the indirect flag, bits 14..11 are the opcode and bits 10..0 are the address. The fetch routine sits at control addresses 64..66. The last fetch step uses a map branch that jumps to control address opcode*4, where each opcode has a four-word routine. Indirect addressing is a shared subroutine at control addresses 67..68. It is called when the indirect flag is set and it replaces the address register with the pointer read from memory.

The test program is written into main memory through a load port while reset is held. The machine starts fetching at address 0 when reset is released. A peek port reads memory without disturbing execution.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the registers reset: the control address (`car`) becomes 64, and `pc` and `acc` become 0. A write through the load port (`ld_we`, `ld_addr`, `ld_data`) stores the word in memory during reset.
- R2: After reset, control runs through 64, 65 and 66, one step per clock. `pc` increases by one in the step at 65 and in no other fetch step.
- R3: The step after 66 goes to control address {0, instr[14:11], 00}, that is opcode*4.
- R4: Opcode 0000 (add) sets `acc` to `acc` plus M[EA]. A direct add takes 6 clocks, fetch included.
- R5: Opcode 0001 (branch) sets `pc` to EA when `acc[15]` is 1 (6 clocks). Otherwise `pc` keeps its value after fetch (5 clocks).
- R6: Opcode 0010 (store) writes `acc` to M[EA] and takes 6 clocks.
- R7: Opcode 0011 (exchange) loads `acc` from M[EA] and writes the old `acc` to M[EA]. It takes 7 clocks.
- R8: When bit 15 is 1, EA is bits 10..0 of M[instr[10:0]]. This adds 2 clocks, and the pointer word is not modified.
- R9: Opcodes 0100..1111 change neither `acc` nor memory. Their routine returns to 64 after one step, so each takes 4 clocks.
- R10: `pc` is 11 bits wide and wraps from 2047 to 0.
- R11: `ld_we` has no effect on memory while `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; memory load allowed while low |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 11 | Load-port word address |
| ld_data | input | 16 | Load-port write data |
| peek_addr | input | 11 | Memory inspection address |
| peek_data | output | 16 | Memory word at `peek_addr` (combinational) |
| acc | output | 16 | Accumulator |
| pc | output | 11 | Program counter |
| car | output | 7 | Current control memory address |

## Verification
On every cycle, the assertions check the fetch ordering 64→65→66, the single program-counter increment in fetch, and that the map target matches the fetched opcode. They also check that unused routines fall straight back to fetch, that `pc` changes only in the increment or branch steps, and the reset values. The arithmetic and memory effects can only be shown by the bench's directed programs, which check accumulator, counter and memory contents after an exact number of clocks. These effects are add and exchange values, store contents, branch decisions on the sign, pointer resolution for indirect operands, and counter wrap.

// File: rtl/ucode_acc_cpu.sv
`timescale 1ns/1ps
module ucode_acc_cpu #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic [DW-1:0] acc,
  output logic [AW-1:0] pc,
  output logic [CW-1:0] car
);
  localparam int MW = 9 + 4 + CW;
  localparam int DEPTH = 1 << AW;
  localparam logic [CW-1:0] FETCH = CW'(64);
  localparam logic [CW-1:0] INDR  = CW'(67);
  localparam logic [CW-1:0] ZAD   = '0;

  localparam logic [2:0] NOP = 3'b000;
  localparam logic [2:0] O1_ADD = 3'b001, O1_DR2AC = 3'b100, O1_DR2AR = 3'b101, O1_PC2AR = 3'b110;
  localparam logic [2:0] O2_RD = 3'b100, O2_AC2DR = 3'b101;
  localparam logic [2:0] O3_WR = 3'b001, O3_AR2PC = 3'b010, O3_INCPC = 3'b101;
  localparam logic [1:0] C_U = 2'b00, C_I = 2'b01, C_S = 2'b10, C_Z = 2'b11;
  localparam logic [1:0] B_JMP = 2'b00, B_CALL = 2'b01, B_RET = 2'b10, B_MAP = 2'b11;

  function automatic logic [MW-1:0] mi(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                                       input logic [1:0] cd, input logic [1:0] br, input logic [CW-1:0] ad);
    return {a, b, c, cd, br, ad};
  endfunction

  function automatic logic [MW-1:0] urom(input logic [CW-1:0] a);
    case (a)
      CW'(0):  urom = mi(NOP, NOP, NOP, C_I, B_CALL, INDR);
      CW'(1):  urom = mi(NOP, O2_RD, NOP, C_U, B_JMP, CW'(2));
      CW'(2):  urom = mi(O1_ADD, NOP, NOP, C_U, B_JMP, FETCH);
      CW'(4):  urom = mi(NOP, NOP, NOP, C_S, B_JMP, CW'(6));
      CW'(5):  urom = mi(NOP, NOP, NOP, C_U, B_JMP, FETCH);
      CW'(6):  urom = mi(NOP, NOP, NOP, C_I, B_CALL, INDR);
      CW'(7):  urom = mi(NOP, NOP, O3_AR2PC, C_U, B_JMP, FETCH);
      CW'(8):  urom = mi(NOP, NOP, NOP, C_I, B_CALL, INDR);
      CW'(9):  urom = mi(NOP, O2_AC2DR, NOP, C_U, B_JMP, CW'(10));
      CW'(10): urom = mi(NOP, NOP, O3_WR, C_U, B_JMP, FETCH);
      CW'(12): urom = mi(NOP, NOP, NOP, C_I, B_CALL, INDR);
      CW'(13): urom = mi(NOP, O2_RD, NOP, C_U, B_JMP, CW'(14));
      CW'(14): urom = mi(O1_DR2AC, O2_AC2DR, NOP, C_U, B_JMP, CW'(15));
      CW'(15): urom = mi(NOP, NOP, O3_WR, C_U, B_JMP, FETCH);
      CW'(64): urom = mi(O1_PC2AR, NOP, NOP, C_U, B_JMP, CW'(65));
      CW'(65): urom = mi(NOP, O2_RD, O3_INCPC, C_U, B_JMP, CW'(66));
      CW'(66): urom = mi(O1_DR2AR, NOP, NOP, C_U, B_MAP, ZAD);
      CW'(67): urom = mi(NOP, O2_RD, NOP, C_U, B_JMP, CW'(68));
      CW'(68): urom = mi(O1_DR2AR, NOP, NOP, C_U, B_RET, ZAD);
      default: urom = mi(NOP, NOP, NOP, C_U, B_JMP, FETCH);
    endcase
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] dr;
  logic [AW-1:0] ar;
  logic [CW-1:0] sbr, car_nx, car_inc;
  logic [MW-1:0] uw;
  logic [2:0] f1, f2, f3;
  logic [1:0] cd, br;
  logic [CW-1:0] ad;
  logic cond;

  assign uw = urom(car);
  assign {f1, f2, f3, cd, br, ad} = uw;
  assign car_inc = car + CW'(1);
  assign peek_data = mem[peek_addr];

  always_comb begin
    case (cd)
      C_U: cond = 1'b1;
      C_I: cond = dr[DW-1];
      C_S: cond = acc[DW-1];
      default: cond = (acc == '0);
    endcase
    case (br)
      B_JMP, B_CALL: car_nx = cond ? ad : car_inc;
      B_RET:         car_nx = sbr;
      default:       car_nx = {1'b0, dr[DW-2:DW-5], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car <= FETCH;
      sbr <= '0;
      pc  <= '0;
      ar  <= '0;
      dr  <= '0;
      acc <= '0;
    end else begin
      car <= car_nx;
      if (br == B_CALL && cond) sbr <= car_inc;
      case (f1)
        O1_ADD:   acc <= acc + dr;
        O1_DR2AC: acc <= dr;
        O1_DR2AR: ar  <= dr[AW-1:0];
        O1_PC2AR: ar  <= pc;
        default: ;
      endcase
      case (f2)
        O2_RD:    dr <= mem[ar];
        O2_AC2DR: dr <= acc;
        default: ;
      endcase
      case (f3)
        O3_INCPC: pc <= pc + AW'(1);
        O3_AR2PC: pc <= ar;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_we) mem[ld_addr] <= ld_data;
    end else if (f3 == O3_WR) begin
      mem[ar] <= dr;
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) !rst_n |=> (car == FETCH && pc == '0 && acc == '0));
  // R2
  fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n) car == FETCH |=> car == FETCH + CW'(1));
  // R2
  fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    car == FETCH + CW'(1) |=> (car == FETCH + CW'(2) && pc == $past(pc) + AW'(1)));
  // R3
  map_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    car == FETCH + CW'(2) |=> (car[CW-1] == 1'b0 && car[1:0] == 2'b00 && car[5:2] == $past(dr[DW-2:DW-5])));
  // R9
  unused_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car >= CW'(16) && car < FETCH) |=> car == FETCH);
  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car != FETCH + CW'(1) && car != CW'(7)) |=> $stable(pc));
endmodule

// File: tb/ucode_acc_cpu_tb_top.sv
`timescale 1ns/1ps
module ucode_acc_cpu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_we = 1'b0;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [10:0] peek_addr = '0;
  logic [15:0] peek_data, acc;
  logic [10:0] pc;
  logic [6:0] car;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ucode_acc_cpu dut_i (.clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
                       .peek_addr(peek_addr), .peek_data(peek_data), .acc(acc), .pc(pc), .car(car));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic ld(input logic [10:0] a, input logic [15:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_run(input int n);
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic peek_chk(input string req, input logic [10:0] a, input logic [15:0] exp);
    peek_addr = a;
    #1;
    chk(req, 32'(peek_data), 32'(exp));
  endtask

  task automatic t_reset();
    hold_reset();
    repeat (2) @(negedge clk);
    chk("R1 car", 32'(car), 32'd64);
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 acc", 32'(acc), 32'd0);
  endtask

  task automatic t_fetch_add();
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd100, 16'h0005);
    peek_chk("R1 load", 11'd100, 16'h0005);
    release_run(1);
    chk("R2 step1 car", 32'(car), 32'd65);
    chk("R2 step1 pc", 32'(pc), 32'd0);
    release_run(1);
    chk("R2 step2 car", 32'(car), 32'd66);
    chk("R2 step2 pc", 32'(pc), 32'd1);
    release_run(1);
    chk("R3 map add", 32'(car), 32'd0);
    release_run(3);
    chk("R4 add acc", 32'(acc), 32'd5);
    chk("R4 back to fetch", 32'(car), 32'd64);
    ld_we = 1'b1; ld_addr = 11'd100; ld_data = 16'h7777;
    @(negedge clk);
    ld_we = 1'b0;
    peek_chk("R11 load ignored", 11'd100, 16'h0005);
  endtask

  task automatic t_add_store_exch();
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd1, 16'h0065);
    ld(11'd2, 16'h10C8);
    ld(11'd3, 16'h1865);
    ld(11'd100, 16'h0007);
    ld(11'd101, 16'h0003);
    ld(11'd200, 16'h0000);
    release_run(12);
    chk("R4 add twice", 32'(acc), 32'd10);
    release_run(6);
    peek_chk("R6 store", 11'd200, 16'd10);
    release_run(7);
    chk("R7 exch acc", 32'(acc), 32'd3);
    peek_chk("R7 exch mem", 11'd101, 16'd10);
    chk("R7 pc", 32'(pc), 32'd4);
  endtask

  task automatic t_branch();
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd1, 16'h0832);
    ld(11'd100, 16'h0005);
    release_run(11);
    chk("R5 not taken pc", 32'(pc), 32'd2);
    chk("R5 not taken car", 32'(car), 32'd64);
    hold_reset();
    ld(11'd100, 16'h8000);
    ld(11'd50, 16'h0065);
    ld(11'd101, 16'h0001);
    release_run(12);
    chk("R5 taken pc", 32'(pc), 32'd50);
    release_run(6);
    chk("R5 after target acc", 32'(acc), 32'h8001);
    chk("R5 after target pc", 32'(pc), 32'd51);
  endtask

  task automatic t_indirect();
    hold_reset();
    ld(11'd0, 16'h8064);
    ld(11'd1, 16'h9065);
    ld(11'd2, 16'h9866);
    ld(11'd100, 16'h012C);
    ld(11'd101, 16'h0190);
    ld(11'd102, 16'h01F4);
    ld(11'd300, 16'h0009);
    ld(11'd400, 16'h0000);
    ld(11'd500, 16'h0004);
    release_run(8);
    chk("R8 indirect add", 32'(acc), 32'd9);
    release_run(8);
    peek_chk("R8 indirect store", 11'd400, 16'd9);
    release_run(9);
    chk("R8 indirect exch acc", 32'(acc), 32'd4);
    peek_chk("R8 indirect exch mem", 11'd500, 16'd9);
    peek_chk("R8 pointer kept", 11'd100, 16'h012C);
    chk("R8 pc", 32'(pc), 32'd3);
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd1, 16'h8865);
    ld(11'd100, 16'h8000);
    ld(11'd101, 16'h0123);
    release_run(14);
    chk("R8 indirect branch pc", 32'(pc), 32'h123);
  endtask

  task automatic t_unused();
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd1, 16'h2864);
    ld(11'd100, 16'h0005);
    release_run(9);
    chk("R9 map unused", 32'(car), 32'd20);
    release_run(1);
    chk("R9 return", 32'(car), 32'd64);
    chk("R9 acc kept", 32'(acc), 32'd5);
    chk("R9 pc", 32'(pc), 32'd2);
    peek_chk("R9 mem kept", 11'd100, 16'h0005);
  endtask

  task automatic t_wrap();
    hold_reset();
    ld(11'd0, 16'h0064);
    ld(11'd1, 16'h0FFF);
    ld(11'd100, 16'h8000);
    ld(11'd2047, 16'h0065);
    ld(11'd101, 16'h0001);
    release_run(12);
    chk("R10 at top", 32'(pc), 32'd2047);
    release_run(6);
    chk("R10 wrapped pc", 32'(pc), 32'd0);
    chk("R10 acc", 32'(acc), 32'h8001);
  endtask

  initial begin
    t_reset();
    t_fetch_add();
    t_add_store_exch();
    t_branch();
    t_indirect();
    t_unused();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule